// File: doc/BRIEF.md
# Bipolar Line Code Violation Monitor

This block sits in the receive path of a digital carrier line, right after the line interface has sliced the bipolar signal and recovered the bit clock. Each bit time it receives two strobes. One marks a positive pulse and the other marks a negative pulse. The block turns this symbol stream back into binary data using one of three line codes chosen by a mode input: plain alternate mark inversion, eight-zero substitution, or the high-density code that replaces four zeros. Polarity violations that a legal substitution code puts on the line on purpose are recognised and removed. Every other violation is flagged and counted.

The decoded bit leaves the block a fixed eight bit clocks after its symbol entered. This gives the pattern detectors an eight-symbol look-ahead window. A violation pulse and an excess-zeros pulse come out in the same cycle as the decoded bit they belong to. A 16-bit counter accumulates violations, stops at its maximum value, and is cleared by a synchronous input. A receiver set to the wrong line code sees the far end's deliberate violations as errors, so a code mismatch shows up at once as a climbing count.

Top module: `bpv_monitor`

## Requirements
- R1: The decoded bit for the symbol captured at clock edge k appears on `data_o` after edge k+8. A mark decodes as 1 and a space decodes as 0. The violation and excess-zeros outputs for that symbol appear in the same cycle.
- R2: With mode 0 (alternate mark inversion, which mode 3 also selects), a mark whose polarity equals the previous mark's polarity raises `bpv_o` for one cycle. The first mark after reset is never a violation.
- R3: With mode 1, the eight-symbol group 0,0,0,V,B,0,V,B decodes as eight zeros and raises no violation. Here V repeats the polarity of the pulse before the group and B has the opposite polarity. Marks after the group must alternate from the last B.
- R4: With mode 2, the groups 0,0,0,V and B,0,0,V decode as four zeros and raise no violation. V must repeat the polarity of the pulse before it, and must have the opposite polarity of the V accepted before it. A V that does not alternate in this way counts as a violation and decodes as 1.
- R5: When the mode does not match the far end's line code, each deliberate violation in the far end's substitution groups is reported as a violation, and its pulses decode as ones.
- R6: A symbol with both strobes high decodes as 1 and is a violation. It does not change the polarity history used to judge later marks.
- R7: `exz_o` pulses once, on the zero that makes a run of physical spaces longer than the mode allows. The limit is 15 zeros in mode 0, 7 zeros in mode 1 and 3 zeros in mode 2.
- R8: `bpv_cnt_o` adds one for each `bpv_o` pulse and holds at 65535 once it gets there.
- R9: While `cnt_clr_i` is high at a clock edge, the counter loads 0, or loads 1 if a violation is reported at that same edge.
- R10: During reset all outputs are 0, the counter is 0 and the polarity history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Line code: 0 alternate mark inversion, 1 eight-zero substitution, 2 four-zero high-density substitution, 3 same as 0 |
| pos_i | input | 1 | Positive pulse seen in this bit time |
| neg_i | input | 1 | Negative pulse seen in this bit time |
| cnt_clr_i | input | 1 | Synchronous clear of the violation counter |
| data_o | output | 1 | Decoded data bit, eight clocks after its symbol |
| bpv_o | output | 1 | One-cycle pulse for a counted violation |
| exz_o | output | 1 | One-cycle pulse when a zero run passes the mode's limit |
| bpv_cnt_o | output | 16 | Saturating violation count |

## Verification
Two functions can act in the same cycle: a counter clear and a new violation. The bench sets up this collision by holding a stream of same-polarity marks and pulsing the clear while violations still leave the pipeline every cycle. It checks that the count reads 1 right after the clear and 2 one cycle later, which shows that no event was lost. It then flushes the pipeline and clears again with no violation present, which must give 0. The saturation step before this drives more than 65536 violations in a row, so the clear also starts from the held maximum.

// File: rtl/bpv_monitor.sv
`timescale 1ns/1ps
module bpv_monitor #(
  parameter int CNT_W    = 16,
  parameter int AMI_ZMAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             cnt_clr_i,
  output logic             data_o,
  output logic             bpv_o,
  output logic             exz_o,
  output logic [CNT_W-1:0] bpv_cnt_o
);
  localparam int W  = 8;
  localparam int ZW = $clog2(AMI_ZMAX + 2);
  localparam logic [1:0] M_SUB8 = 2'd1;
  localparam logic [1:0] M_SUB4 = 2'd2;

  // window slots: bit 0 newest, bit W-1 oldest
  logic [W-1:0] sv, sm, se, sp, ss;
  logic [W-1:0] nv, nm, ne, np, ns;
  logic         last_pol, seen, lastv_pol, vseen;
  logic [ZW-1:0] zrun, zlim;

  assign nv = {sv[W-2:0], 1'b1};
  assign nm = {sm[W-2:0], pos_i ^ neg_i};
  assign ne = {se[W-2:0], pos_i & neg_i};
  assign np = {sp[W-2:0], pos_i};
  assign ns = {ss[W-2:0], 1'b0};

  // polarity of the last physical pulse before the oldest next-window slot
  logic base_pol, base_ok;
  assign base_pol = sm[W-1] ? sp[W-1] : last_pol;
  assign base_ok  = sm[W-1] | seen;

  logic s8_hit;
  assign s8_hit = (mode_i == M_SUB8) && (&nv) && !(|ne) && !(|ns) && base_ok &&
                  (nm == 8'b0001_1011) &&
                  (np[4] == base_pol) && (np[3] != base_pol) &&
                  (np[1] != base_pol) && (np[0] == base_pol);

  logic h_pol, h_ok;
  always_comb begin
    h_pol = base_pol;
    h_ok  = base_ok;
    for (int i = W-1; i >= 4; i--) begin
      if (nm[i]) begin
        h_pol = np[i];
        h_ok  = 1'b1;
      end
    end
  end

  logic h_shape, h_plain, h_bal, s4_hit;
  assign h_shape = (&nv[3:0]) && !(|ne[3:0]) && !(|ns[3:1]) && !nm[2] && !nm[1] && nm[0];
  assign h_plain = !nm[3] && (np[0] == h_pol);
  assign h_bal   = nm[3] && (np[3] != h_pol) && (np[0] == np[3]);
  assign s4_hit  = (mode_i == M_SUB4) && h_ok && h_shape && (h_plain || h_bal) &&
                   (!vseen || (np[0] != lastv_pol));

  logic [W-1:0] smask;
  assign smask = s8_hit ? {W{1'b1}} : (s4_hit ? {{(W-4){1'b0}}, 4'hF} : '0);

  logic viol, zero;
  assign viol = sv[W-1] & (se[W-1] | (sm[W-1] & ~ss[W-1] & seen & (sp[W-1] == last_pol)));
  assign zero = sv[W-1] & ~sm[W-1] & ~se[W-1];
  assign zlim = (mode_i == M_SUB8) ? ZW'(7) : ((mode_i == M_SUB4) ? ZW'(3) : ZW'(AMI_ZMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0; sm <= '0; se <= '0; sp <= '0; ss <= '0;
      last_pol <= 1'b0; seen <= 1'b0; lastv_pol <= 1'b0; vseen <= 1'b0;
      zrun <= '0;
      data_o <= 1'b0; bpv_o <= 1'b0; exz_o <= 1'b0;
      bpv_cnt_o <= '0;
    end else begin
      sv <= nv; sm <= nm; se <= ne; sp <= np; ss <= ns | smask;
      if (sm[W-1]) begin
        last_pol <= sp[W-1];
        seen     <= 1'b1;
      end
      if (s4_hit) begin
        lastv_pol <= np[0];
        vseen     <= 1'b1;
      end
      if (!zero)            zrun <= '0;
      else if (zrun != '1)  zrun <= zrun + 1'b1;
      data_o <= sv[W-1] & (se[W-1] | (sm[W-1] & ~ss[W-1]));
      bpv_o  <= viol;
      exz_o  <= zero && (zrun == zlim);
      if (cnt_clr_i)                      bpv_cnt_o <= {{(CNT_W-1){1'b0}}, viol};
      else if (viol && bpv_cnt_o != '1)   bpv_cnt_o <= bpv_cnt_o + 1'b1;
    end
  end

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_cnt_o == '1 && !cnt_clr_i) |=> (bpv_cnt_o == '1));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_o && !$past(cnt_clr_i) && $past(bpv_cnt_o) != '1) |->
      (bpv_cnt_o == $past(bpv_cnt_o) + {{(CNT_W-1){1'b0}}, 1'b1}));
  a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr_i) |-> (bpv_cnt_o >= $past(bpv_cnt_o)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr_i) |-> (bpv_cnt_o == {{(CNT_W-1){1'b0}}, bpv_o}));
  a_r3_sub_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sv[W-1] && ss[W-1]) |=> (!data_o && !bpv_o));
  a_r6_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (sv[W-1] && se[W-1]) |=> (data_o && bpv_o));
  a_r7_exz_on_space: assert property (@(posedge clk) disable iff (!rst_n)
    exz_o |-> (!data_o && !bpv_o));
  a_r4_one_sub_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(s8_hit && s4_hit));
endmodule

// File: tb/bpv_monitor_tb_top.sv
`timescale 1ns/1ps
module bpv_monitor_tb_top;
  localparam int MAXN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pos = 1'b0, neg = 1'b0, clr = 1'b0;
  logic data, bpv, exz;
  logic [15:0] cnt;

  int vec = 0, bad = 0;
  bit done = 1'b0;
  bit bits_a[MAXN];
  bit sp_a[MAXN];
  bit sn_a[MAXN];
  bit ed[MAXN];
  bit ev[MAXN];
  bit ez[MAXN];
  int nb = 0, n = 0;

  always #2.5 clk = ~clk;

  bpv_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pos_i(pos), .neg_i(neg),
    .cnt_clr_i(clr), .data_o(data), .bpv_o(bpv), .exz_o(exz), .bpv_cnt_o(cnt)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input int i, input bit pol);
    sp_a[i] = pol; sn_a[i] = !pol;
  endtask

  task automatic spc(input int i);
    sp_a[i] = 1'b0; sn_a[i] = 1'b0;
  endtask

  task automatic build_src();
    nb = 0;
    for (int b = 0; b < 261; b++) begin
      logic [7:0] v;
      v = (b == 0 || b == 260) ? 8'hFF : ((b >= 257) ? 8'h00 : 8'(b - 1));
      for (int j = 7; j >= 0; j--) begin
        bits_a[nb] = v[j];
        nb++;
      end
    end
  endtask

  task automatic enc_ami();
    bit last = 1'b0;
    for (int i = 0; i < nb; i++) begin
      if (bits_a[i]) begin last = !last; put(i, last); end
      else spc(i);
    end
    n = nb;
  endtask

  task automatic enc_sub8();
    bit last = 1'b0;
    int i = 0;
    while (i < nb) begin
      if (bits_a[i]) begin
        last = !last; put(i, last); i++;
      end else if (i + 7 < nb && !(bits_a[i] | bits_a[i+1] | bits_a[i+2] | bits_a[i+3] |
                                   bits_a[i+4] | bits_a[i+5] | bits_a[i+6] | bits_a[i+7])) begin
        spc(i); spc(i+1); spc(i+2); put(i+3, last); put(i+4, !last);
        spc(i+5); put(i+6, !last); put(i+7, last);
        i += 8;
      end else begin
        spc(i); i++;
      end
    end
    n = nb;
  endtask

  task automatic enc_sub4();
    bit last = 1'b0;
    int ones = 0;
    int i = 0;
    while (i < nb) begin
      if (bits_a[i]) begin
        last = !last; put(i, last); ones++; i++;
      end else if (i + 3 < nb && !(bits_a[i] | bits_a[i+1] | bits_a[i+2] | bits_a[i+3])) begin
        if (ones % 2 == 0) begin
          last = !last; put(i, last);
        end else spc(i);
        spc(i+1); spc(i+2); put(i+3, last);
        ones = 0; i += 4;
      end else begin
        spc(i); i++;
      end
    end
    n = nb;
  endtask

  // alternation rule over the physical stream (R2, R5, R6)
  task automatic ami_expect();
    bit seen = 1'b0, last = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (sp_a[i] && sn_a[i]) begin
        ed[i] = 1'b1; ev[i] = 1'b1;
      end else if (sp_a[i] || sn_a[i]) begin
        ed[i] = 1'b1; ev[i] = seen && (sp_a[i] == last);
        last = sp_a[i]; seen = 1'b1;
      end else begin
        ed[i] = 1'b0; ev[i] = 1'b0;
      end
    end
  endtask

  task automatic src_expect();
    for (int i = 0; i < n; i++) begin ed[i] = bits_a[i]; ev[i] = 1'b0; end
  endtask

  task automatic z_expect(input int lim);
    int run = 0;
    for (int i = 0; i < n; i++) begin
      if (sp_a[i] || sn_a[i]) run = 0; else run++;
      ez[i] = !(sp_a[i] || sn_a[i]) && (run == lim + 1);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; pos = 1'b0; neg = 1'b0; clr = 1'b0; mode = m;
    repeat (3) @(negedge clk);
    chk("R10", "data in reset", data, 0);
    chk("R10", "bpv in reset", bpv, 0);
    chk("R10", "exz in reset", exz, 0);
    chk("R10", "count in reset", cnt, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input string tag);
    int sum = 0;
    for (int k = 0; k < n + 9; k++) begin
      if (k >= 9) begin
        chk(tag, $sformatf("data[%0d]", k-9), data, ed[k-9]);
        chk(tag, $sformatf("bpv[%0d]", k-9), bpv, ev[k-9]);
        chk("R7", $sformatf("exz[%0d]", k-9), exz, ez[k-9]);
      end
      pos = (k < n) ? sp_a[k] : 1'b0;
      neg = (k < n) ? sn_a[k] : 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) sum += ev[i];
    chk("R8", "count after stream", cnt, sum);
  endtask

  task automatic hand(input int len, input string pat);
    for (int i = 0; i < len; i++) begin
      case (pat[i])
        "+": begin sp_a[i] = 1'b1; sn_a[i] = 1'b0; end
        "-": begin sp_a[i] = 1'b0; sn_a[i] = 1'b1; end
        "x": begin sp_a[i] = 1'b1; sn_a[i] = 1'b1; end
        default: begin sp_a[i] = 1'b0; sn_a[i] = 1'b0; end
      endcase
    end
    n = len;
  endtask

  initial begin
    #950000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    build_src();
    // R1: every byte value, alternate mark inversion
    enc_ami(); ami_expect(); z_expect(15); do_reset(2'd0); run_stream("R1");
    // R3: eight-zero substitution restored
    enc_sub8(); src_expect(); z_expect(7); do_reset(2'd1); run_stream("R3");
    // R4: four-zero substitution restored
    enc_sub4(); src_expect(); z_expect(3); do_reset(2'd2); run_stream("R4");
    // R5: far end substitutes, receiver expects plain alternation
    enc_sub8(); ami_expect(); z_expect(15); do_reset(2'd0); run_stream("R5");
    enc_sub4(); ami_expect(); z_expect(15); do_reset(2'd3); run_stream("R5");
    // R7: plain stream with long spaces judged against substitution limits
    enc_ami(); ami_expect(); z_expect(3); do_reset(2'd2); run_stream("R7");
    enc_ami(); ami_expect(); z_expect(7); do_reset(2'd1); run_stream("R7");
    // R2: repeated polarity
    hand(10, "+-0-++-0+0"); ami_expect(); z_expect(15); do_reset(2'd0); run_stream("R2");
    // R6: both strobes keep history
    hand(10, "+-+x+-x-+0"); ami_expect(); z_expect(15); do_reset(2'd0); run_stream("R6");
    // R4: second V with same polarity as the first is a violation
    hand(10, "+000+000+-"); z_expect(3);
    for (int i = 0; i < 10; i++) begin ed[i] = 1'b0; ev[i] = 1'b0; end
    ed[0] = 1'b1; ed[8] = 1'b1; ed[9] = 1'b1; ev[8] = 1'b1;
    do_reset(2'd2); run_stream("R4");
    // R8 saturation, then R9 clear colliding with a violation
    do_reset(2'd0);
    pos = 1'b1; neg = 1'b0;
    repeat (65600) @(negedge clk);
    chk("R8", "saturated count", cnt, 65535);
    chk("R8", "bpv while saturated", bpv, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "clear with violation", cnt, 1);
    @(negedge clk);
    chk("R9", "count after clear", cnt, 2);
    pos = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9", "count after flush", cnt, 10);
    chk("R2", "bpv after flush", bpv, 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "clear without violation", cnt, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule